// File: doc/BRIEF.md
# Pointer-Indexed Host RAM Access Port

This block connects a legacy PC-style host bus, 8 or 16 bits wide, to a 1K x 16 buffer RAM held inside the block. A configuration strap, latched during reset, picks one of three ways for the host to reach the RAM.

- **8-bit I/O window:** the host loads a byte pointer through two 8-bit registers, then streams bytes through a data register.
- **16-bit I/O window:** the same pointer and data registers are reached as whole words or as single byte lanes.
- **16-bit memory window:** the host address lines name the RAM word directly, with no pointer involved.

The block steers data onto the byte lanes and drives the two active-low 16-bit acknowledges. When auto-increment is enabled, it advances the pointer after each access that finishes with the upper byte of a data-register word. Every bus cycle completes in one clock. A read returns data in the same cycle, and a write lands at the closing clock edge.

Any combination of select lines, lane enables and register code that the access table does not define is rejected. Such a cycle raises an error output, leaves the RAM and the pointer untouched, and reads back all ones.

Top module: `host_ram_port`

## Requirements
- R1: While reset is low the mode strap (0 = 8-bit I/O, 1 = 16-bit I/O, 2 = 16-bit memory; code 3 behaves as 0) and the auto-increment strap are captured, and the pointer is cleared to zero; both straps are ignored after reset.
- R2: In 8-bit I/O mode, register code 0 with A0=0 reaches the pointer low byte and with A0=1 the pointer high byte (pointer bits 10..8 in bits 2..0). Every transfer, including an 8-bit memory access at byte address A10..A0, uses D0..D7 only, and neither 16-bit acknowledge is asserted.
- R3: In 8-bit I/O mode the data register (register code 1) reaches the RAM byte at the 11-bit byte pointer, where pointer bit 0 selects the upper byte. With auto-increment enabled, each data access adds one to the byte pointer.
- R4: In 16-bit I/O mode, pointer and data accesses decode A0/SBHE# as follows: 0/0 is a word on both lanes, 0/1 is the even byte on D0..D7, and 1/0 is the odd byte on D8..D15. Each of these asserts the I/O acknowledge (low).
- R5: In 16-bit I/O mode, a pointer load through the low lane forces pointer bit 0 to zero. The pointer high byte on D8..D15 holds pointer bits 10..8.
- R6: In 16-bit I/O mode with auto-increment enabled, a data word access and an odd-byte data access advance the pointer by one word, and an even-byte access does not. With auto-increment disabled, no data access moves the pointer.
- R7: In 16-bit memory mode, A10..A1 select the RAM word and A0/SBHE# select the lanes with the R4 encoding. Each such access asserts the memory acknowledge (low).
- R8: The pointer wraps from the last RAM location to zero on increment, whether it counts words or bytes.
- R9: An access is illegal if it has both selects, both strobes, A0=1 with SBHE#=1 in a 16-bit lane decode, an I/O pointer or data access in memory mode, or a memory access in 16-bit I/O mode. An illegal access raises the error output, writes nothing, keeps the pointer, and reads 0xFFFF on both lanes with no acknowledge.
- R10: I/O register codes 2 and 3 belong to other register files. They drive no lanes, assert no acknowledge, raise no error and change neither RAM nor pointer.
- R11: Read data is driven only on the lanes flagged in the lane-enable output. Lanes that are not enabled read zero, and writes reach only the RAM bytes of the decoded lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; straps are captured while low |
| cfg_mode | input | 2 | Mode strap sampled in reset |
| cfg_autoinc | input | 1 | Auto-increment strap sampled in reset |
| bus_io_sel | input | 1 | I/O cycle aimed at this block's register window |
| bus_mem_sel | input | 1 | Memory cycle aimed at the RAM window |
| bus_reg | input | 2 | I/O register code: 0 pointer, 1 data, 2/3 other |
| bus_addr | input | 11 | Host address A10..A0 |
| bus_sbhe_n | input | 1 | Active-low byte-high enable |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data D15..D0 |
| bus_rdata | output | 16 | Read data D15..D0 |
| bus_rd_oe | output | 2 | Read lane enables (bit 0 = D0..D7, bit 1 = D8..D15) |
| iocs16_n | output | 1 | Active-low 16-bit I/O acknowledge |
| memcs16_n | output | 1 | Active-low 16-bit memory acknowledge |
| bus_err | output | 1 | Illegal access flag |

## Verification
The lane and acknowledge decode is swept over every pairing of select lines, register code, A0 and SBHE# in each mode. This separates the word, even-byte, odd-byte, out-of-scope and illegal outcomes, and shows which acknowledge belongs to which mode. Directed write and read-back sequences then check each increment rule against its neighbours. They show that word and odd-byte accesses advance the pointer while even-byte accesses do not, and that 8-bit accesses step by bytes. The pointer is parked at the last RAM location to observe the wrap, and low-lane pointer loads use an odd value to show bit 0 being cleared. RAM contents persist across the resets that change mode, so data written through the 16-bit pointer path is read back through the 8-bit and memory paths, which tells lane steering errors apart from addressing errors.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

    typedef enum logic [1:0] {
        MODE_IO8   = 2'd0,
        MODE_IO16  = 2'd1,
        MODE_MEM16 = 2'd2
    } mode_e;

    // Outcome of decoding one bus cycle
    typedef struct packed {
        logic [1:0] bus_ln;   // host lanes carrying data
        logic [1:0] ram_ln;   // RAM byte lanes touched
        logic       is_ram;   // cycle reaches the RAM
        logic       ptr_lo;   // pointer low byte addressed
        logic       ptr_hi;   // pointer high byte addressed
        logic       inc;      // pointer advances after this cycle
        logic       io16;     // 16-bit I/O acknowledge
        logic       mem16;    // 16-bit memory acknowledge
        logic       bad;      // combination outside the access table
    } dec_t;

endpackage

// File: rtl/hrp_decode.sv
module hrp_decode
    import hrp_pkg::*;
#(
    parameter int PTR_W = 11
) (
    input  mode_e            mode_i,
    input  logic             autoinc_i,
    input  logic [PTR_W-1:0] ptr_i,
    input  logic             io_sel_i,
    input  logic             mem_sel_i,
    input  logic [1:0]       reg_i,
    input  logic [PTR_W-1:0] addr_i,
    input  logic             sbhe_n_i,
    input  logic             rd_i,
    input  logic             wr_i,
    output dec_t             dec_o,
    output logic [PTR_W-2:0] word_o
);

    logic [1:0] lanes16;
    logic       conflict;

    always_comb begin
        // A0/SBHE#: 00 word, 01 even, 10 odd, 11 nothing
        lanes16  = {~sbhe_n_i, ~addr_i[0]};
        conflict = (io_sel_i && mem_sel_i) || (rd_i && wr_i);
        word_o   = io_sel_i ? ptr_i[PTR_W-1:1] : addr_i[PTR_W-1:1];
        dec_o    = '0;

        if ((io_sel_i || mem_sel_i) && conflict) begin
            dec_o.bad = 1'b1;
        end else if (io_sel_i && !reg_i[1]) begin
            case (mode_i)
                MODE_IO8: begin
                    dec_o.bus_ln = 2'b01;
                    dec_o.ptr_lo = (reg_i == 2'd0) && !addr_i[0];
                    dec_o.ptr_hi = (reg_i == 2'd0) && addr_i[0];
                    if (reg_i == 2'd1) begin
                        dec_o.is_ram = 1'b1;
                        dec_o.ram_ln = ptr_i[0] ? 2'b10 : 2'b01;
                        dec_o.inc    = autoinc_i;
                    end
                end
                MODE_IO16: begin
                    if (lanes16 == 2'b00) begin
                        dec_o.bad = 1'b1;
                    end else begin
                        dec_o.bus_ln = lanes16;
                        dec_o.io16   = 1'b1;
                        dec_o.ptr_lo = (reg_i == 2'd0) && lanes16[0];
                        dec_o.ptr_hi = (reg_i == 2'd0) && lanes16[1];
                        if (reg_i == 2'd1) begin
                            dec_o.is_ram = 1'b1;
                            dec_o.ram_ln = lanes16;
                            dec_o.inc    = autoinc_i && lanes16[1];
                        end
                    end
                end
                default: dec_o.bad = 1'b1;
            endcase
        end else if (mem_sel_i) begin
            case (mode_i)
                MODE_IO8: begin
                    dec_o.bus_ln = 2'b01;
                    dec_o.is_ram = 1'b1;
                    dec_o.ram_ln = addr_i[0] ? 2'b10 : 2'b01;
                end
                MODE_MEM16: begin
                    if (lanes16 == 2'b00) begin
                        dec_o.bad = 1'b1;
                    end else begin
                        dec_o.bus_ln = lanes16;
                        dec_o.ram_ln = lanes16;
                        dec_o.is_ram = 1'b1;
                        dec_o.mem16  = 1'b1;
                    end
                end
                default: dec_o.bad = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/hrp_ptr.sv
module hrp_ptr
    import hrp_pkg::*;
#(
    parameter int PTR_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_mode_i,
    input  logic             cfg_autoinc_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic [7:0]       lo_byte_i,
    input  logic [7:0]       hi_byte_i,
    input  logic             inc_i,
    output mode_e            mode_o,
    output logic             autoinc_o,
    output logic [PTR_W-1:0] ptr_o
);

    localparam int HI_W = PTR_W - 8;

    typedef struct packed {
        mode_e            mode;
        logic             autoinc;
        logic [PTR_W-1:0] ptr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            // strap code 3 falls back to the 8-bit window
            st_d.mode    = (cfg_mode_i == 2'd3) ? MODE_IO8 : mode_e'(cfg_mode_i);
            st_d.autoinc = cfg_autoinc_i;
            st_d.ptr     = '0;
        end else begin
            if (wr_lo_i) begin
                if (st_q.mode == MODE_IO8) st_d.ptr[7:0] = lo_byte_i;
                else                       st_d.ptr[7:0] = {lo_byte_i[7:1], 1'b0};
            end
            if (wr_hi_i) st_d.ptr[PTR_W-1:8] = hi_byte_i[HI_W-1:0];
            if (inc_i) begin
                if (st_q.mode == MODE_IO8) st_d.ptr = st_q.ptr + PTR_W'(1);
                else                       st_d.ptr = st_q.ptr + PTR_W'(2);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mode_o    = st_q.mode;
    assign autoinc_o = st_q.autoinc;
    assign ptr_o     = st_q.ptr;

    // R1
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(st_q.mode) && $stable(st_q.autoinc)));

    // R8
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && st_q.mode != MODE_IO8 && (&st_q.ptr[PTR_W-1:1]))
        |=> (ptr_o == '0));

endmodule

// File: rtl/hrp_ram.sv
module hrp_ram #(
    parameter int WORD_AW = 10
) (
    input  logic               clk,
    input  logic [WORD_AW-1:0] addr_i,
    input  logic [1:0]         we_i,
    input  logic [15:0]        wdata_i,
    output logic [15:0]        rdata_o
);

    localparam int DEPTH = 1 << WORD_AW;

    for (genvar ln = 0; ln < 2; ln++) begin : g_lane
        logic [7:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we_i[ln]) mem_q[addr_i] <= wdata_i[ln*8 +: 8];
        end

        assign rdata_o[ln*8 +: 8] = mem_q[addr_i];
    end

endmodule

// File: rtl/host_ram_port.sv
module host_ram_port
    import hrp_pkg::*;
#(
    parameter int WORD_AW = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_mode,
    input  logic               cfg_autoinc,
    input  logic               bus_io_sel,
    input  logic               bus_mem_sel,
    input  logic [1:0]         bus_reg,
    input  logic [WORD_AW:0]   bus_addr,
    input  logic               bus_sbhe_n,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [15:0]        bus_wdata,
    output logic [15:0]        bus_rdata,
    output logic [1:0]         bus_rd_oe,
    output logic               iocs16_n,
    output logic               memcs16_n,
    output logic               bus_err
);

    localparam int PTR_W = WORD_AW + 1;

    mode_e              mode;
    logic               autoinc;
    logic [PTR_W-1:0]   ptr;
    dec_t               dec;
    logic [WORD_AW-1:0] ram_word;
    logic [15:0]        ram_rdata;
    logic [15:0]        ram_wdata;
    logic [1:0]         ram_we;
    logic               strobe, ok, is8;
    logic [15:0]        ptr16, raw_d;
    logic [7:0]         hi_src;

    hrp_decode #(.PTR_W(PTR_W)) u_dec (
        .mode_i    (mode),
        .autoinc_i (autoinc),
        .ptr_i     (ptr),
        .io_sel_i  (bus_io_sel),
        .mem_sel_i (bus_mem_sel),
        .reg_i     (bus_reg),
        .addr_i    (bus_addr),
        .sbhe_n_i  (bus_sbhe_n),
        .rd_i      (bus_rd),
        .wr_i      (bus_wr),
        .dec_o     (dec),
        .word_o    (ram_word)
    );

    always_comb begin
        strobe    = bus_rd || bus_wr;
        ok        = strobe && !dec.bad;
        is8       = (mode == MODE_IO8);
        hi_src    = is8 ? bus_wdata[7:0] : bus_wdata[15:8];
        ram_wdata = is8 ? {bus_wdata[7:0], bus_wdata[7:0]} : bus_wdata;
        ram_we    = (bus_wr && ok && dec.is_ram) ? dec.ram_ln : 2'b00;
    end

    hrp_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_mode_i    (cfg_mode),
        .cfg_autoinc_i (cfg_autoinc),
        .wr_lo_i       (bus_wr && ok && dec.ptr_lo),
        .wr_hi_i       (bus_wr && ok && dec.ptr_hi),
        .lo_byte_i     (bus_wdata[7:0]),
        .hi_byte_i     (hi_src),
        .inc_i         (ok && dec.inc),
        .mode_o        (mode),
        .autoinc_o     (autoinc),
        .ptr_o         (ptr)
    );

    hrp_ram #(.WORD_AW(WORD_AW)) u_ram (
        .clk     (clk),
        .addr_i  (ram_word),
        .we_i    (ram_we),
        .wdata_i (ram_wdata),
        .rdata_o (ram_rdata)
    );

    always_comb begin
        ptr16 = 16'(ptr);
        raw_d = '0;
        if (dec.is_ram) begin
            if (is8) raw_d = {8'h00, dec.ram_ln[1] ? ram_rdata[15:8] : ram_rdata[7:0]};
            else     raw_d = ram_rdata;
        end else if (dec.ptr_lo || dec.ptr_hi) begin
            if (is8) raw_d = {8'h00, dec.ptr_hi ? ptr16[15:8] : ptr16[7:0]};
            else     raw_d = ptr16;
        end

        bus_err = strobe && dec.bad;
        if (bus_err && bus_rd) begin
            bus_rdata = '1;
            bus_rd_oe = 2'b11;
        end else if (bus_rd && ok) begin
            bus_rdata = raw_d & {{8{dec.bus_ln[1]}}, {8{dec.bus_ln[0]}}};
            bus_rd_oe = dec.bus_ln;
        end else begin
            bus_rdata = '0;
            bus_rd_oe = 2'b00;
        end
        iocs16_n  = !(dec.io16 && !dec.bad);
        memcs16_n = !(dec.mem16 && !dec.bad);
    end

    // R9
    err_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> $stable(ptr));

    // R2
    io8_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IO8) |-> (iocs16_n && memcs16_n));

    // R4
    ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!iocs16_n && !memcs16_n));

    // R11
    lane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd_oe[0] || bus_rdata[7:0] == 8'h00) &&
         (bus_rd_oe[1] || bus_rdata[15:8] == 8'h00)));

    // R7
    mem_ack_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !memcs16_n |-> (mode == MODE_MEM16 && bus_mem_sel));

endmodule

// File: tb/sim_host_ram_port.sv
module sim_host_ram_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_autoinc = 1'b0;
    logic        io_sel = 1'b0, mem_sel = 1'b0;
    logic [1:0]  rg = 2'd0;
    logic [10:0] addr = '0;
    logic        sbhe_n = 1'b1, rd = 1'b0, wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  oe;
    logic        iocs16_n, memcs16_n, err;

    logic [15:0] s_data;
    logic [1:0]  s_oe;
    logic        s_io, s_mem, s_err;
    int          n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    host_ram_port u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_autoinc(cfg_autoinc),
        .bus_io_sel(io_sel), .bus_mem_sel(mem_sel), .bus_reg(rg), .bus_addr(addr),
        .bus_sbhe_n(sbhe_n), .bus_rd(rd), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata), .bus_rd_oe(oe), .iocs16_n(iocs16_n),
        .memcs16_n(memcs16_n), .bus_err(err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m, input logic ai);
        @(negedge clk);
        cfg_mode = m; cfg_autoinc = ai; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cfg_mode = ~m; cfg_autoinc = ~ai;   // straps must be ignored now
    endtask

    task automatic acc(input logic i, input logic m, input logic [1:0] r, input logic [10:0] a,
                       input logic sb, input logic rr, input logic ww, input logic [15:0] wd);
        @(negedge clk);
        io_sel = i; mem_sel = m; rg = r; addr = a; sbhe_n = sb; rd = rr; wr = ww; wdata = wd;
        #1;
        s_data = rdata; s_oe = oe; s_io = iocs16_n; s_mem = memcs16_n; s_err = err;
        @(posedge clk);
        #1;
        io_sel = 1'b0; mem_sel = 1'b0; rd = 1'b0; wr = 1'b0;
    endtask

    // {err, iocs16_n, memcs16_n, oe} expected for a read
    function automatic logic [4:0] exp_dec(input int md, input logic i, input logic m,
                                           input logic [1:0] r, input logic a0, input logic sb);
        logic [1:0] l;
        logic       bad;
        logic [4:0] e;
        l = {~sb, ~a0};
        bad = 1'b0;
        e = 5'b01100;
        if (i && m) bad = 1'b1;
        else if (i) begin
            if (r < 2) begin
                if (md == 0) e[1:0] = 2'b01;
                else if (md == 1) begin
                    if (l == 2'b00) bad = 1'b1;
                    else begin e[1:0] = l; e[3] = 1'b0; end
                end else bad = 1'b1;
            end
        end else begin
            if (md == 0) e[1:0] = 2'b01;
            else if (md == 1) bad = 1'b1;
            else if (l == 2'b00) bad = 1'b1;
            else begin e[1:0] = l; e[2] = 1'b0; end
        end
        if (bad) e = 5'b11111;
        return e;
    endfunction

    task automatic sweep(input int md);
        for (int c = 1; c < 4; c++)
            for (int r = 0; r < 4; r++)
                for (int a0 = 0; a0 < 2; a0++)
                    for (int sb = 0; sb < 2; sb++) begin
                        acc(c[0], c[1], 2'(r), {10'h003, 1'(a0)}, 1'(sb), 1'b1, 1'b0, 16'h0);
                        chk($sformatf("R4 R7 R9 R10 decode md=%0d c=%0d r=%0d a0=%0d sb=%0d",
                                      md, c, r, a0, sb),
                            {27'd0, s_err, s_io, s_mem, s_oe},
                            {27'd0, exp_dec(md, c[0], c[1], 2'(r), 1'(a0), 1'(sb))});
                    end
    endtask

    task automatic rd_chk(input string tag, input logic i, input logic m, input logic [1:0] r,
                          input logic [10:0] a, input logic sb,
                          input logic [1:0] e_oe, input logic [15:0] e_d);
        acc(i, m, r, a, sb, 1'b1, 1'b0, 16'h0);
        chk(tag, {14'd0, s_oe, s_data}, {14'd0, e_oe, e_d});
    endtask

    initial begin
        // ---- 16-bit I/O, auto-increment off ----
        do_reset(2'd1, 1'b0);
        rd_chk("R1 ptr reset", 1, 0, 2'd0, 11'h0, 0, 2'b11, 16'h0000);
        sweep(1);
        rd_chk("R6 no inc when off", 1, 0, 2'd0, 11'h0, 0, 2'b11, 16'h0000);

        // ---- 16-bit I/O, auto-increment on ----
        do_reset(2'd1, 1'b1);
        acc(1, 0, 2'd0, 11'h0, 0, 0, 1, 16'h07FE);
        rd_chk("R5 ptr word load", 1, 0, 2'd0, 11'h0, 0, 2'b11, 16'h07FE);
        acc(1, 0, 2'd1, 11'h0, 0, 0, 1, 16'hA1A1);
        rd_chk("R8 word wrap", 1, 0, 2'd0, 11'h0, 0, 2'b11, 16'h0000);
        acc(1, 0, 2'd1, 11'h0, 0, 0, 1, 16'hB2B2);
        acc(1, 0, 2'd1, 11'h0, 1, 0, 1, 16'h00C3);
        rd_chk("R6 even no inc", 1, 0, 2'd0, 11'h0, 0, 2'b11, 16'h0002);
        acc(1, 0, 2'd1, 11'h1, 0, 0, 1, 16'hD400);
        rd_chk("R6 odd inc", 1, 0, 2'd0, 11'h0, 0, 2'b11, 16'h0004);
        acc(1, 0, 2'd0, 11'h0, 1, 0, 1, 16'h0003);
        rd_chk("R5 low lane bit0 forced", 1, 0, 2'd0, 11'h0, 0, 2'b11, 16'h0002);
        rd_chk("R4 data word read", 1, 0, 2'd1, 11'h0, 0, 2'b11, 16'hD4C3);
        acc(1, 0, 2'd1, 11'h1, 1, 0, 1, 16'hEEEE);
        chk("R9 err flag", {31'd0, s_err}, 32'd1);
        rd_chk("R9 ptr kept", 1, 0, 2'd0, 11'h0, 0, 2'b11, 16'h0004);
        acc(1, 0, 2'd1, 11'h1, 1, 1, 0, 16'h0);
        chk("R9 illegal read", {13'd0, s_err, s_oe, s_data}, {13'd0, 1'b1, 2'b11, 16'hFFFF});
        acc(1, 0, 2'd0, 11'h1, 0, 0, 1, 16'h0500);
        rd_chk("R5 ptr high lane", 1, 0, 2'd0, 11'h1, 0, 2'b10, 16'h0500);
        acc(1, 0, 2'd2, 11'h0, 0, 0, 1, 16'h0000);
        chk("R10 other reg", {27'd0, s_err, s_io, s_mem, s_oe}, {27'd0, 5'b01100});
        rd_chk("R10 ptr untouched", 1, 0, 2'd0, 11'h0, 0, 2'b11, 16'h0504);

        // ---- 8-bit I/O, auto-increment off ----
        do_reset(2'd0, 1'b0);
        sweep(0);

        // ---- 8-bit I/O, auto-increment on ----
        do_reset(2'd0, 1'b1);
        rd_chk("R1 ptr reset 8", 1, 0, 2'd0, 11'h0, 1, 2'b01, 16'h0000);
        acc(1, 0, 2'd0, 11'h0, 1, 0, 1, 16'h0002);
        acc(1, 0, 2'd0, 11'h1, 1, 0, 1, 16'h0000);
        rd_chk("R3 byte even", 1, 0, 2'd1, 11'h0, 1, 2'b01, 16'h00C3);
        rd_chk("R3 byte odd", 1, 0, 2'd1, 11'h0, 1, 2'b01, 16'h00D4);
        rd_chk("R3 byte inc", 1, 0, 2'd0, 11'h0, 1, 2'b01, 16'h0004);
        acc(1, 0, 2'd1, 11'h0, 1, 0, 1, 16'h005A);
        rd_chk("R2 8-bit mem read", 0, 1, 2'd0, 11'h004, 1, 2'b01, 16'h005A);
        acc(1, 0, 2'd0, 11'h0, 1, 0, 1, 16'h00FF);
        acc(1, 0, 2'd0, 11'h1, 1, 0, 1, 16'h0007);
        rd_chk("R2 ptr high byte", 1, 0, 2'd0, 11'h1, 1, 2'b01, 16'h0007);
        rd_chk("R3 last byte", 1, 0, 2'd1, 11'h0, 1, 2'b01, 16'h00A1);
        rd_chk("R8 byte wrap lo", 1, 0, 2'd0, 11'h0, 1, 2'b01, 16'h0000);
        rd_chk("R8 byte wrap hi", 1, 0, 2'd0, 11'h1, 1, 2'b01, 16'h0000);

        // ---- 16-bit memory ----
        do_reset(2'd2, 1'b0);
        sweep(2);
        rd_chk("R7 word at A10..A1", 0, 1, 2'd0, 11'h002, 0, 2'b11, 16'hD4C3);
        rd_chk("R7 top word", 0, 1, 2'd0, 11'h7FE, 0, 2'b11, 16'hA1A1);
        acc(0, 1, 2'd0, 11'h005, 0, 0, 1, 16'h7700);
        rd_chk("R11 odd write lane", 0, 1, 2'd0, 11'h004, 0, 2'b11, 16'h775A);
        rd_chk("R11 even read", 0, 1, 2'd0, 11'h004, 1, 2'b01, 16'h005A);
        rd_chk("R11 odd read", 0, 1, 2'd0, 11'h005, 0, 2'b10, 16'h7700);
        acc(0, 1, 2'd0, 11'h005, 1, 0, 1, 16'h1111);
        chk("R9 mem illegal err", {31'd0, s_err}, 32'd1);
        rd_chk("R9 mem no write", 0, 1, 2'd0, 11'h004, 0, 2'b11, 16'h775A);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule